// File: doc/BRIEF.md
# Address Translation Mode Registers

This block keeps the control registers that decide whether a single-hart RISC-V core translates virtual addresses, and with which scheme. It holds the supervisor address-translation register (satp), the virtual-supervisor register (vsatp), the guest-stage register (hgatp) and the H bit of misa. Each is a write-any-read-legal register: a write whose mode value the build does not support is dropped in full, so a read always returns a legal mode.

Three build-time parameters shape what is kept. `XLEN` picks the layout of the mode field: a single bit at 31 for 32-bit builds, or a four-bit field at 63:60 for 64-bit builds. `MMU_EN` decides whether paging exists at all. `HYP_EN` decides whether the hypervisor bit can be set. From the stored state the block drives three enables: supervisor translation, virtual-supervisor translation and guest-stage translation. The TLBs and the page-table walker consume these enables.

Accesses come through a plain CSR port with an address, write data, a write strobe and registered read data.

Top module: `xlate_mode_csr`

## Requirements
- R1: After reset every register reads as zero (Bare mode, H clear) and all three translation enables are low.
- R2: With XLEN = 32 the satp mode is bit 31. Both values are legal, and 1 selects Sv32 and raises the supervisor enable. Bits 30:0 are stored as written.
- R3: With XLEN = 64 the satp mode is bits 63:60. Value 0 is Bare and value 8 is Sv39, and Sv39 raises the supervisor enable. Bits 59:0 are stored as written.
- R4: In a 64-bit build, a write to satp, vsatp or hgatp whose bits 63:60 are neither 0 nor 8 leaves the whole register unchanged.
- R5: With MMU_EN = 0, satp always reads zero, writes to it are ignored, and the supervisor enable stays low.
- R6: misa is at CSR address 0x301. With HYP_EN = 1, writing it stores only bit 7 (the H bit), which is clear after reset. A read returns bit 7 and zero in every other bit.
- R7: With HYP_EN = 0, misa bit 7 stays 0 whatever is written.
- R8: While the H bit is clear, writes to vsatp and hgatp are ignored, and the virtual-supervisor and guest-stage enables are low. Stored values survive a clear of H and take effect again when H is set.
- R9: With H set, writing 8 to vsatp bits 63:60 raises the virtual-supervisor enable. Writing 8 to hgatp bits 63:60 selects Sv39x4 and raises the guest-stage enable.
- R10: The CSR addresses are satp 0x180, vsatp 0x280 and hgatp 0x680. Read data for the address presented in one cycle appears after the next rising edge. Any other address reads zero.
- R11: A legal write takes effect on the clock edge that samples it, and the enables reflect the new mode from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_addr_i | input | 12 | CSR address for read and write |
| csr_wdata_i | input | XLEN | Write data |
| csr_we_i | input | 1 | Write strobe, one access per cycle |
| csr_rdata_o | output | XLEN | Registered read data |
| s_xlate_en_o | output | 1 | Supervisor translation active |
| vs_xlate_en_o | output | 1 | Virtual-supervisor translation active |
| g_xlate_en_o | output | 1 | Guest-stage translation active |

## Verification
Three instances are driven with the same stream of accesses: a 64-bit build with paging and hypervisor support, a 32-bit build with paging only, and a 64-bit build without paging.

One satp write can be legal in one layout and illegal in another. For example, a value with bits 63:60 = 9 but bit 31 = 0 is dropped by the 64-bit build and kept by the 32-bit one, which separates the two legality rules.

Writes to vsatp and hgatp are issued both before and after the H bit is set. Mode values 8 and 0xA are each tried. This tells apart gating by H, gating by mode value, and retention of stored state across a clear and re-set of H.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
   localparam logic [11:0] CSR_SATP  = 12'h180;
   localparam logic [11:0] CSR_VSATP = 12'h280;
   localparam logic [11:0] CSR_HGATP = 12'h680;
   localparam logic [11:0] CSR_MISA  = 12'h301;

   localparam int unsigned HBIT_POS  = 7;
   localparam logic [3:0]  MODE_PG39 = 4'd8;
   localparam logic [3:0]  MODE_BARE = 4'd0;

   // index of each address-translation register in the bank
   localparam int unsigned IDX_S  = 0;
   localparam int unsigned IDX_VS = 1;
   localparam int unsigned IDX_G  = 2;
   localparam int unsigned N_ATP  = 3;

   function automatic logic [11:0] atp_addr(int unsigned idx);
      case (idx)
         IDX_S:   return CSR_SATP;
         IDX_VS:  return CSR_VSATP;
         default: return CSR_HGATP;
      endcase
   endfunction

   function automatic logic wide_mode_ok(logic [3:0] m);
      return (m == MODE_BARE) || (m == MODE_PG39);
   endfunction
endpackage

// File: rtl/xlate_atp_reg.sv
module xlate_atp_reg
   import xlate_pkg::*;
#(
   parameter int unsigned XLEN   = 64,
   parameter bit          ENABLE = 1'b1,
   parameter logic [11:0] ADDR   = 12'h180
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [11:0]     addr_i,
   input  logic [XLEN-1:0] wdata_i,
   input  logic            we_i,
   input  logic            gate_i,
   output logic [XLEN-1:0] value_o,
   output logic            active_o
);
   localparam int unsigned MW   = (XLEN == 32) ? 1 : 4;
   localparam int unsigned MLSB = XLEN - MW;

   logic            legal;
   logic            sel;
   logic [XLEN-1:0] value_q;

   assign sel = we_i && (addr_i == ADDR);

   generate
      if (XLEN == 32) begin : g_narrow
         // single mode bit: both encodings are legal
         assign legal = 1'b1;
      end else begin : g_wide
         assign legal = wide_mode_ok(wdata_i[XLEN-1:MLSB]);

         p_bad_mode_hold_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
            (sel && !legal) |=> $stable(value_o));
      end
   endgenerate

   generate
      if (ENABLE) begin : g_store
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               value_q <= '0;
            end else if (sel && gate_i && legal) begin
               value_q <= wdata_i;
            end
         end

         p_store_r11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
            (sel && gate_i && legal) |=> (value_o == $past(wdata_i)));
      end else begin : g_absent
         assign value_q = '0;
      end
   endgenerate

   assign value_o  = value_q;
   assign active_o = |value_q[XLEN-1:MLSB];

   p_gate_hold_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel && !gate_i) |=> $stable(value_o));
endmodule

// File: rtl/xlate_hbit.sv
module xlate_hbit
   import xlate_pkg::*;
#(
   parameter bit ENABLE = 1'b1
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic [11:0] addr_i,
   input  logic        wbit_i,
   input  logic        we_i,
   output logic        h_o
);
   generate
      if (ENABLE) begin : g_store
         logic h_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               h_q <= 1'b0;
            end else if (we_i && (addr_i == CSR_MISA)) begin
               h_q <= wbit_i;
            end
         end
         assign h_o = h_q;

         p_hbit_follow_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
            (we_i && (addr_i == CSR_MISA)) |=> (h_o == $past(wbit_i)));
      end else begin : g_absent
         assign h_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/xlate_rdmux.sv
module xlate_rdmux
   import xlate_pkg::*;
#(
   parameter int unsigned XLEN = 64
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic [11:0]            addr_i,
   input  logic [N_ATP-1:0][XLEN-1:0] atp_i,
   input  logic                   h_i,
   output logic [XLEN-1:0]        rdata_o
);
   logic [XLEN-1:0] rd_next;
   logic [XLEN-1:0] rd_q;

   always_comb begin
      rd_next = '0;
      case (addr_i)
         CSR_SATP:  rd_next = atp_i[IDX_S];
         CSR_VSATP: rd_next = atp_i[IDX_VS];
         CSR_HGATP: rd_next = atp_i[IDX_G];
         CSR_MISA:  rd_next[HBIT_POS] = h_i;
         default:   rd_next = '0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rd_q <= '0;
      else         rd_q <= rd_next;
   end

   assign rdata_o = rd_q;

   p_unmapped_zero_r10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (addr_i != CSR_SATP && addr_i != CSR_VSATP && addr_i != CSR_HGATP &&
       addr_i != CSR_MISA) |=> (rdata_o == '0));
endmodule

// File: rtl/xlate_mode_csr.sv
module xlate_mode_csr
   import xlate_pkg::*;
#(
   parameter int unsigned XLEN   = 64,
   parameter bit          MMU_EN = 1'b1,
   parameter bit          HYP_EN = 1'b1
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [11:0]     csr_addr_i,
   input  logic [XLEN-1:0] csr_wdata_i,
   input  logic            csr_we_i,
   output logic [XLEN-1:0] csr_rdata_o,
   output logic            s_xlate_en_o,
   output logic            vs_xlate_en_o,
   output logic            g_xlate_en_o
);
   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("xlate_mode_csr: XLEN must be 32 or 64");
      end
      if (HYP_EN && (XLEN != 64 || !MMU_EN)) begin : g_bad_hyp
         $error("xlate_mode_csr: HYP_EN needs XLEN 64 and MMU_EN");
      end
   endgenerate

   logic                       h_bit;
   logic [N_ATP-1:0][XLEN-1:0] atp_val;
   logic [N_ATP-1:0]           atp_on;

   xlate_hbit #(.ENABLE(HYP_EN)) u_hbit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .addr_i (csr_addr_i),
      .wbit_i (csr_wdata_i[HBIT_POS]),
      .we_i   (csr_we_i),
      .h_o    (h_bit)
   );

   for (genvar gi = 0; gi < N_ATP; gi++) begin : g_atp
      localparam bit ENA = (gi == IDX_S) ? MMU_EN : HYP_EN;
      logic gate;
      assign gate = (gi == IDX_S) ? 1'b1 : h_bit;

      xlate_atp_reg #(
         .XLEN   (XLEN),
         .ENABLE (ENA),
         .ADDR   (atp_addr(gi))
      ) u_reg (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .addr_i   (csr_addr_i),
         .wdata_i  (csr_wdata_i),
         .we_i     (csr_we_i),
         .gate_i   (gate),
         .value_o  (atp_val[gi]),
         .active_o (atp_on[gi])
      );
   end

   xlate_rdmux #(.XLEN(XLEN)) u_rd (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .addr_i  (csr_addr_i),
      .atp_i   (atp_val),
      .h_i     (h_bit),
      .rdata_o (csr_rdata_o)
   );

   assign s_xlate_en_o  = atp_on[IDX_S];
   assign vs_xlate_en_o = h_bit && atp_on[IDX_VS];
   assign g_xlate_en_o  = h_bit && atp_on[IDX_G];

   p_guest_off_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (csr_we_i && csr_addr_i == CSR_MISA && !csr_wdata_i[HBIT_POS])
      |=> (!vs_xlate_en_o && !g_xlate_en_o));

   generate
      if (!MMU_EN) begin : g_chk_nommu
         p_no_paging_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
            (csr_addr_i == CSR_SATP) |=> (csr_rdata_o == '0 && !s_xlate_en_o));
      end
      if (!HYP_EN) begin : g_chk_nohyp
         p_hbit_stuck_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
            (csr_addr_i == CSR_MISA) |=> (csr_rdata_o == '0));
      end
   endgenerate
endmodule

// File: tb/sim_xlate_mode_csr.sv
module sim_xlate_mode_csr;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] addr = '0;
   logic [63:0] wdata = '0;
   logic        we = 1'b0;

   logic [63:0] rd0, rd2;
   logic [31:0] rd1;
   logic        s0, v0, g0, s1, v1, g1, s2, v2, g2;

   int unsigned cyc = 0;
   int          n_run = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   xlate_mode_csr #(.XLEN(64), .MMU_EN(1'b1), .HYP_EN(1'b1)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .csr_addr_i(addr), .csr_wdata_i(wdata),
      .csr_we_i(we), .csr_rdata_o(rd0), .s_xlate_en_o(s0),
      .vs_xlate_en_o(v0), .g_xlate_en_o(g0));

   xlate_mode_csr #(.XLEN(32), .MMU_EN(1'b1), .HYP_EN(1'b0)) u1 (
      .clk_i(clk), .rst_ni(rst_n), .csr_addr_i(addr), .csr_wdata_i(wdata[31:0]),
      .csr_we_i(we), .csr_rdata_o(rd1), .s_xlate_en_o(s1),
      .vs_xlate_en_o(v1), .g_xlate_en_o(g1));

   xlate_mode_csr #(.XLEN(64), .MMU_EN(1'b0), .HYP_EN(1'b0)) u2 (
      .clk_i(clk), .rst_ni(rst_n), .csr_addr_i(addr), .csr_wdata_i(wdata),
      .csr_we_i(we), .csr_rdata_o(rd2), .s_xlate_en_o(s2),
      .vs_xlate_en_o(v2), .g_xlate_en_o(g2));

   typedef struct {
      int unsigned due;
      bit          chk_rd;
      logic [63:0] e0;
      logic [31:0] e1;
      logic [63:0] e2;
      logic [2:0]  en0;   // {guest, virtual-supervisor, supervisor}
      logic        en1;
      string       req;
   } item_t;

   item_t sb[$];

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // driver: one access per cycle, expectation due after the sampling edge
   task automatic op(input bit wr, input logic [11:0] a, input logic [63:0] d,
                     input logic [63:0] e0, input logic [31:0] e1,
                     input logic [63:0] e2, input logic [2:0] en0,
                     input logic en1, input string req);
      item_t it;
      @(negedge clk);
      addr  = a;
      wdata = d;
      we    = wr;
      it.due = cyc + 1;
      it.chk_rd = !wr;
      it.e0 = e0; it.e1 = e1; it.e2 = e2;
      it.en0 = en0; it.en1 = en1; it.req = req;
      sb.push_back(it);
   endtask

   // monitor
   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].due <= cyc) begin
         item_t it;
         it = sb.pop_front();
         if (it.chk_rd) begin
            check(rd0 === it.e0, it.req, "u0 rdata", rd0, it.e0);
            check(rd1 === it.e1, it.req, "u1 rdata", {32'd0, rd1}, {32'd0, it.e1});
            check(rd2 === it.e2, it.req, "u2 rdata", rd2, it.e2);
         end
         check({g0, v0, s0} === it.en0, it.req, "u0 enables",
               {61'd0, g0, v0, s0}, {61'd0, it.en0});
         check({g1, v1, s1} === {2'b00, it.en1}, it.req, "u1 enables",
               {61'd0, g1, v1, s1}, {62'd0, it.en1});
         check({g2, v2, s2} === 3'b000, "R5", "u2 enables",
               {61'd0, g2, v2, s2}, 64'd0);
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state on every register
      op(0, 12'h180, 0, 0, 0, 0, 3'b000, 0, "R1");
      op(0, 12'h280, 0, 0, 0, 0, 3'b000, 0, "R1");
      op(0, 12'h680, 0, 0, 0, 0, 3'b000, 0, "R1");
      op(0, 12'h301, 0, 0, 0, 0, 3'b000, 0, "R1");
      // R3 R11: Sv39 on the wide build; R2: bit31=0 kept as Bare; R5 no paging
      op(1, 12'h180, 64'h8000_0000_0001_2345, 0, 0, 0, 3'b001, 0, "R11");
      op(0, 12'h180, 0, 64'h8000_0000_0001_2345, 32'h0001_2345, 0, 3'b001, 0, "R3");
      // R4: mode 9 dropped on the wide build, accepted by the narrow one (R2)
      op(1, 12'h180, 64'h9000_0000_0000_00FF, 0, 0, 0, 3'b001, 0, "R4");
      op(0, 12'h180, 0, 64'h8000_0000_0001_2345, 32'h0000_00FF, 0, 3'b001, 0, "R4");
      // R2: Sv32 via bit 31; wide build back to Bare
      op(1, 12'h180, 64'h0000_0000_8000_0042, 0, 0, 0, 3'b000, 1, "R2");
      op(0, 12'h180, 0, 64'h0000_0000_8000_0042, 32'h8000_0042, 0, 3'b000, 1, "R2");
      // R8: vsatp write while H clear is ignored
      op(1, 12'h280, 64'h8000_0000_0000_0077, 0, 0, 0, 3'b000, 1, "R8");
      op(0, 12'h280, 0, 0, 0, 0, 3'b000, 1, "R8");
      // R6 R7: set H, only bit 7 kept, absent where HYP_EN=0
      op(1, 12'h301, 64'h0000_0000_0000_00A5, 0, 0, 0, 3'b000, 1, "R6");
      op(0, 12'h301, 0, 64'h80, 0, 0, 3'b000, 1, "R7");
      // R9: virtual-supervisor and guest stage enables
      op(1, 12'h280, 64'h8000_0000_0000_0077, 0, 0, 0, 3'b010, 1, "R9");
      op(0, 12'h280, 0, 64'h8000_0000_0000_0077, 0, 0, 3'b010, 1, "R9");
      op(1, 12'h680, 64'h8000_0000_0000_0099, 0, 0, 0, 3'b110, 1, "R9");
      op(0, 12'h680, 0, 64'h8000_0000_0000_0099, 0, 0, 3'b110, 1, "R9");
      // R4: illegal hgatp mode 0xA keeps old value
      op(1, 12'h680, 64'hA000_0000_0000_0011, 0, 0, 0, 3'b110, 1, "R4");
      op(0, 12'h680, 0, 64'h8000_0000_0000_0099, 0, 0, 3'b110, 1, "R4");
      // R8: clear H, enables drop, stored value retained
      op(1, 12'h301, 64'h0, 0, 0, 0, 3'b000, 1, "R8");
      op(0, 12'h280, 0, 64'h8000_0000_0000_0077, 0, 0, 3'b000, 1, "R8");
      op(1, 12'h280, 64'h0, 0, 0, 0, 3'b000, 1, "R8");
      op(1, 12'h301, 64'h80, 0, 0, 0, 3'b110, 1, "R8");
      // R10: unmapped address reads zero
      op(0, 12'h123, 0, 0, 0, 0, 3'b110, 1, "R10");
      op(0, 12'h180, 0, 64'h0000_0000_8000_0042, 32'h8000_0042, 0, 3'b110, 1, "R10");
      @(negedge clk);
      we = 1'b0;
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule